// File: doc/BRIEF.md
# Stacked-Carrier PWM Modulator for One Multilevel Converter Leg

This block makes the switch commands for one phase leg of an m-level clamped converter. It compares an unsigned reference sample against m-1 triangle carriers stacked on top of each other. The number of carriers below the reference is the output level. That level is turned into 2(m-1) gate commands whose ON switches always form one unbroken run of neighbours.

All carriers come from a single up/down counter. Carrier j is that counter plus j times the programmed peak, so the bands fill the reference range with no gaps. The reference and the peak are both captured only at the triangle valley. Every switch turn-on waits a programmable number of clock cycles. Turn-offs take effect at once.

Each phase of a three-phase system uses its own copy of the block, driven with its own reference. A low enable parks the counter at zero and drops every gate.

Top module: `mlc_modulator`

## Requirements
- R1: The shared carrier counter starts at 0 and steps by one per clock up to the captured peak P. It then steps back down to 0, giving a triangle of period 2P cycles. Band j (j = 0 .. m-2) has the value j*P plus the counter.
- R2: The level is the number of bands whose value is strictly below the captured reference. It is therefore bounded at m-1, which holds whenever the reference exceeds (m-1)*P.
- R3: While the captured reference and a nonzero peak stay unchanged, the level moves by at most one step from one cycle to the next.
- R4: The reference and peak inputs are captured only on a cycle in which the counter is 0 and enable is high. At any other time, changes on those inputs have no effect on the gates.
- R5: Gate bit i drives switch i, counted from the bottom of the stack. Level k commands switches k through k+m-2 ON and all other switches OFF.
- R6: At most m-1 gates are ON in any cycle. Exactly m-1 are ON once the commanded window has been steady for longer than the dead time.
- R7: A switch leaving the window goes OFF one clock after the window register changes. A switch entering the window goes ON only after a further dead-time count of cycles.
- R8: While enable is low, the counter is held at 0. All gates are OFF from the third clock after enable falls.
- R9: Under synchronous reset, all gates are OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Modulator enable |
| period_i | input | CNT_W | Carrier peak P, captured at the valley |
| ref_i | input | CNT_W+2 | Unsigned reference sample, captured at the valley |
| deadtime_i | input | DT_W | Turn-on delay in clock cycles |
| gate_o | output | 2*(M_LEVELS-1) | Switch commands, bit 0 at the bottom of the stack |

## Verification
A cycle-accurate scoreboard model is checked against the design under several stimulus patterns, each of which separates different kinds of fault:
- A short peak with a mid-band reference exposes errors in the triangle turnaround.
- Fixed references in the lower, middle and upper bands separate the band offsets from one another.
- References at zero and far above the top band pin the lowest and highest windows and test the level bound.
- A slow ramp catches multi-step level jumps.
- Reference changes at times unrelated to the carrier show whether capture happens anywhere but the valley.
- Runs with zero dead time and with a long dead time, and an enable drop in the middle of a run, separate turn-on delay from turn-off and check the idle state.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tri_dir_e;
endpackage

// File: rtl/mlc_carrier.sv
// Shared triangle counter plus valley capture of reference and peak.
module mlc_carrier #(
  parameter int CNT_W = 8,
  parameter int REF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [REF_W-1:0] ref_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [REF_W-1:0] ref_q_o,
  output logic [CNT_W-1:0] per_q_o
);
  import mlc_pkg::*;

  tri_dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      dir_q   <= DIR_UP;
      ref_q_o <= '0;
      per_q_o <= '0;
    end else if (!en_i) begin
      cnt_o <= '0;
      dir_q <= DIR_UP;
    end else begin
      // capture only at the valley
      if (cnt_o == '0) begin
        ref_q_o <= ref_i;
        per_q_o <= period_i;
      end
      if (dir_q == DIR_UP) begin
        if (cnt_o < per_q_o) begin
          cnt_o <= cnt_o + 1'b1;
        end else begin
          dir_q <= DIR_DOWN;
          cnt_o <= (cnt_o == '0) ? '0 : cnt_o - 1'b1;
        end
      end else begin
        if (cnt_o == '0) begin
          dir_q <= DIR_UP;
          cnt_o <= (per_q_o != '0) ? CNT_W'(1) : '0;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mlc_level.sv
// Per-band compare and level count.
module mlc_level #(
  parameter int M_LEVELS = 4,
  parameter int CNT_W    = 8,
  parameter int REF_W    = 10,
  parameter int LVL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [REF_W-1:0] ref_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             act_o
);
  localparam int BANDS = M_LEVELS - 1;
  localparam int CW    = REF_W + 1;

  logic [BANDS-1:0] below;
  logic [LVL_W-1:0] lvl_d;

  for (genvar j = 0; j < BANDS; j++) begin : g_band
    logic [CW-1:0] carrier;
    assign carrier  = CW'(j) * CW'(per_i) + CW'(cnt_i);
    assign below[j] = carrier < CW'(ref_i);
  end

  always_comb begin
    lvl_d = '0;
    for (int j = 0; j < BANDS; j++) begin
      lvl_d = lvl_d + LVL_W'(below[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= '0;
      act_o <= 1'b0;
    end else begin
      lvl_o <= en_i ? lvl_d : '0;
      act_o <= en_i;
    end
  end
endmodule

// File: rtl/mlc_deadtime.sv
// One switch: immediate turn-off, delayed turn-on.
module mlc_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            want_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            gate_o
);
  logic [DT_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      gate_o <= 1'b0;
    end else if (!want_i) begin
      tmr_q  <= dt_i;
      gate_o <= 1'b0;
    end else if (tmr_q != '0) begin
      tmr_q  <= tmr_q - 1'b1;
      gate_o <= 1'b0;
    end else begin
      gate_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mlc_modulator.sv
module mlc_modulator #(
  parameter  int M_LEVELS = 4,
  parameter  int CNT_W    = 8,
  parameter  int DT_W     = 4,
  localparam int REF_W    = CNT_W + 2,
  localparam int NSW      = 2 * (M_LEVELS - 1),
  localparam int LVL_W    = $clog2(M_LEVELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [REF_W-1:0] ref_i,
  input  logic [DT_W-1:0]  deadtime_i,
  output logic [NSW-1:0]   gate_o
);
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] ref_q;
  logic [CNT_W-1:0] per_q;
  logic [LVL_W-1:0] lvl_q;
  logic             act_q;
  logic [NSW-1:0]   want_d;
  logic [NSW-1:0]   want_q;

  mlc_carrier #(.CNT_W(CNT_W), .REF_W(REF_W)) u_carrier (
    .clk(clk), .rst(rst), .en_i(en_i), .period_i(period_i), .ref_i(ref_i),
    .cnt_o(cnt), .ref_q_o(ref_q), .per_q_o(per_q)
  );

  mlc_level #(.M_LEVELS(M_LEVELS), .CNT_W(CNT_W), .REF_W(REF_W), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst(rst), .en_i(en_i), .cnt_i(cnt), .per_i(per_q), .ref_i(ref_q),
    .lvl_o(lvl_q), .act_o(act_q)
  );

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    always_comb begin
      want_d[i] = act_q && (i >= int'(lvl_q)) && (i < int'(lvl_q) + M_LEVELS - 1);
    end

    mlc_deadtime #(.DT_W(DT_W)) u_dt (
      .clk(clk), .rst(rst), .want_i(want_q[i]), .dt_i(deadtime_i), .gate_o(gate_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) want_q <= '0;
    else     want_q <= want_d;
  end
endmodule

// File: rtl/mlc_modulator_chk.sv
module mlc_modulator_chk #(
  parameter int M_LEVELS = 4,
  parameter int CNT_W    = 8,
  parameter int REF_W    = 10,
  parameter int NSW      = 6,
  parameter int LVL_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic [NSW-1:0]   gate_o,
  input logic [NSW-1:0]   want_q,
  input logic [LVL_W-1:0] lvl_q,
  input logic             act_q,
  input logic [REF_W-1:0] ref_q,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] cnt
);
  p_gate_count_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_o) <= M_LEVELS - 1);

  p_turnoff_r7: assert property (@(posedge clk) disable iff (rst)
    (gate_o & ~$past(want_q)) == '0);

  p_adjacent_r3: assert property (@(posedge clk) disable iff (rst)
    (act_q && $past(act_q) && $past(per_q) != '0 &&
     $past(ref_q) == $past(ref_q, 2) && $past(per_q) == $past(per_q, 2))
    |-> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 1 || $past(lvl_q) == lvl_q + 1));

  p_sample_valley_r4: assert property (@(posedge clk) disable iff (rst)
    (ref_q != $past(ref_q)) |-> ($past(cnt) == '0 && $past(en_i)));

  p_idle_gates_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i, 3) |-> gate_o == '0);

  p_idle_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> cnt == '0);
endmodule

bind mlc_modulator mlc_modulator_chk #(
  .M_LEVELS(M_LEVELS), .CNT_W(CNT_W), .REF_W(REF_W), .NSW(NSW), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .gate_o(gate_o), .want_q(want_q),
  .lvl_q(lvl_q), .act_q(act_q), .ref_q(ref_q), .per_q(per_q), .cnt(cnt)
);

// File: tb/tb_mlc_modulator.sv
module tb_mlc_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int M     = 4;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int REF_W = CNT_W + 2;
  localparam int NSW   = 2 * (M - 1);

  typedef struct {
    logic [NSW-1:0] exp;
    string          tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst;
  logic             en;
  logic [CNT_W-1:0] per;
  logic [REF_W-1:0] refv;
  logic [DT_W-1:0]  dt;
  logic [NSW-1:0]   gate;

  item_t sb_q[$];
  string cur_tag = "R9";
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mlc_modulator #(.M_LEVELS(M), .CNT_W(CNT_W), .DT_W(DT_W)) dut (
    .clk(clk), .rst(rst), .en_i(en), .period_i(per), .ref_i(refv),
    .deadtime_i(dt), .gate_o(gate)
  );

  task automatic check(bit ok, string tag, logic [NSW-1:0] act, logic [NSW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: gate actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard model, built from the requirements.
  int             m_cnt, m_ref, m_per, m_lvl;
  bit             m_up, m_act;
  bit [NSW-1:0]   m_want, m_gate;
  int             m_strk[NSW];

  always @(posedge clk) begin
    item_t it;
    int    lvl_n;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_ref = 0; m_per = 0; m_lvl = 0; m_act = 0;
      m_want = '0; m_gate = '0;
      for (int i = 0; i < NSW; i++) m_strk[i] = 0;
    end else begin
      for (int i = 0; i < NSW; i++) begin
        m_strk[i] = m_want[i] ? m_strk[i] + 1 : 0;
        m_gate[i] = m_want[i] && (m_strk[i] > int'(dt));
      end
      for (int i = 0; i < NSW; i++)
        m_want[i] = m_act && (i >= m_lvl) && (i < m_lvl + M - 1);
      lvl_n = 0;
      for (int j = 0; j < M - 1; j++)
        if (j * m_per + m_cnt < m_ref) lvl_n++;
      m_lvl = en ? lvl_n : 0;
      m_act = en;
      if (!en) begin
        m_cnt = 0; m_up = 1;
      end else begin
        bit at_valley;
        at_valley = (m_cnt == 0);
        if (m_up) begin
          if (m_cnt < m_per) m_cnt = m_cnt + 1;
          else begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = (m_per != 0) ? 1 : 0; end
          else m_cnt = m_cnt - 1;
        end
        if (at_valley) begin m_ref = int'(refv); m_per = int'(per); end
      end
    end
    it.exp = m_gate;
    it.tag = cur_tag;
    sb_q.push_back(it);
  end

  // Monitor.
  always @(negedge clk) begin
    item_t it;
    if (!done && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(gate === it.exp, it.tag, gate, it.exp);
      check($countones(gate) <= M - 1, "R6", gate, it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; per = 8'd10; refv = '0; dt = 4'd2;
    cur_tag = "R9";
    step(5);
    check(gate == '0, "R9", gate, '0);
    rst = 1'b0;
    cur_tag = "R8";
    step(10);
    cur_tag = "R1";
    per = 8'd3; refv = 10'd4; en = 1'b1;
    step(40);
    cur_tag = "R2";
    per = 8'd10; refv = 10'd15; step(60);
    refv = 10'd25; step(60);
    refv = 10'd0; step(45);
    check(gate == 6'b000111, "R5", gate, 6'b000111);
    check($countones(gate) == M - 1, "R6", gate, 6'b000111);
    refv = 10'd40; step(45);
    check(gate == 6'b111000, "R2", gate, 6'b111000);
    check($countones(gate) == M - 1, "R6", gate, 6'b111000);
    cur_tag = "R3";
    for (int v = 0; v <= 40; v++) begin
      refv = REF_W'(v);
      step(2);
    end
    cur_tag = "R4";
    for (int k = 0; k < 10; k++) begin
      refv = REF_W'((k * 7) % 35);
      step(7);
    end
    cur_tag = "R7";
    en = 1'b0; step(4);
    dt = 4'd0; en = 1'b1; refv = 10'd15; step(60);
    en = 1'b0; step(4);
    dt = 4'd6; en = 1'b1; refv = 10'd22; step(80);
    cur_tag = "R8";
    en = 1'b0; step(12);
    check(gate == '0, "R8", gate, '0);
    en = 1'b1; refv = 10'd12; step(30);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule